// File: doc/BRIEF.md
# TLB Random Replacement Index Generator

This block supplies a pseudo-random slot number for TLB refills. Each accepted request produces one index that lies at or above a lower bound (the count of entries pinned by software) and below the number of TLB entries. Indices come from a 32-bit right-shifting Galois LFSR. The LFSR state is reduced into the allowed window by a remainder unit that works over several cycles.

The block never hands out the same index on two consecutive requests. If a new candidate equals the last returned index, the LFSR advances again and the block draws a fresh candidate. A request therefore takes a variable number of cycles. When the lower bound leaves no room to pick from, the top entry is returned at once.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and the lower bound is sampled on that edge. `req_ready` stays low until the result has been delivered, so only one request is ever in flight. The result side has no back-pressure: `out_valid` pulses for one cycle, and the consumer must take `out_idx` in that cycle.

Top module: `tlb_rand_idx`

## Requirements
- R1: After reset, `req_ready` is high, `out_valid` is low, the LFSR state is 1 and the remembered last index is 0.
- R2: Each LFSR advance shifts the 32-bit state right by one. If the bit shifted out was 1, the result is XORed with 0xD0000001.
- R3: For a lower bound `w` below ENTRIES-1, a candidate is (LFSR state mod (ENTRIES-w)) + w, taken after the advance. Every returned index lies in [w, ENTRIES-1].
- R4: A candidate equal to the last returned index is rejected. The LFSR advances and another candidate is drawn, until one differs. The returned index becomes the new last index.
- R5: If `w` >= ENTRIES-1, the result is ENTRIES-1 and the LFSR does not advance. That result also becomes the last index.
- R6: A request is accepted on an edge with `req_valid` and `req_ready` both high. `req_ready` is low from the next cycle until the cycle after the `out_valid` pulse.
- R7: Each accepted request yields exactly one `out_valid` pulse, one cycle long. `out_valid` never rises without an outstanding request.
- R8: `wired` is sampled only at acceptance. Changing it while a request is in flight has no effect on that result.
- R9: The LFSR advances only while drawing for a request. Idle cycles between requests leave the sequence of results unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request for a new index |
| req_ready | output | 1 | Block can accept a request |
| wired | input | $clog2(ENTRIES)+1 | Lower bound of the index window |
| out_valid | output | 1 | One-cycle pulse: `out_idx` holds a result |
| out_idx | output | $clog2(ENTRIES) | Returned index |

## Verification
The hardest behaviour to reach from the ports is the redraw after a repeated candidate. With a wide window a repeat is rare, so the stimulus sets the lower bound to ENTRIES-2. That leaves two legal slots, so about half of all first candidates hit the previous index and must be redrawn, and the results must alternate strictly. Saturated bounds (equal to and above ENTRIES-1) are placed between ordinary draws. This shows that they leave the LFSR alone but still overwrite the remembered index. The bench also changes the bound while a request is in flight to show that it is ignored.

// File: rtl/tlb_rand_pkg.sv
package tlb_rand_pkg;
  localparam int          LFSR_W    = 32;
  localparam logic [31:0] LFSR_TAPS = 32'hD000_0001;
  localparam logic [31:0] LFSR_SEED = 32'h0000_0001;

  typedef enum logic [0:0] {ST_IDLE, ST_DRAW} draw_st_e;

  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return (s >> 1) ^ (s[0] ? LFSR_TAPS : '0);
  endfunction
endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr
  import tlb_rand_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  output logic [LFSR_W-1:0] state_o,
  output logic [LFSR_W-1:0] next_o
);
  logic [LFSR_W-1:0] state_q;

  assign next_o  = lfsr_next(state_q);
  assign state_o = state_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       state_q <= LFSR_SEED;
    else if (step_en) state_q <= next_o;
  end
endmodule

// File: rtl/tlb_mod_unit.sv
// Remainder unit: processes STEP_BITS dividend bits per cycle, MSB first.
module tlb_mod_unit #(
  parameter int DW        = 32,
  parameter int DVW       = 5,
  parameter int STEP_BITS = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [DW-1:0]  dividend,
  input  logic [DVW-1:0] divisor,
  output logic           done,
  output logic [DVW-1:0] rem
);
  localparam int STEPS = DW / STEP_BITS;
  localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic [DW-1:0]  dvd_q;
  logic [DVW-1:0] div_q;
  logic [DVW-1:0] rem_q;
  logic [CW-1:0]  cnt_q;
  logic           busy_q;
  logic           done_q;

  logic [DVW-1:0] chain [0:STEP_BITS];
  assign chain[0] = rem_q;

  for (genvar g = 0; g < STEP_BITS; g++) begin : g_bit
    logic [DVW:0] sh;
    logic [DVW:0] dif;
    assign sh  = {chain[g], dvd_q[DW-1-g]};
    assign dif = sh - {1'b0, div_q};
    assign chain[g+1] = (sh >= {1'b0, div_q}) ? dif[DVW-1:0] : sh[DVW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dvd_q  <= '0;
      div_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        dvd_q  <= dividend;
        div_q  <= divisor;
        rem_q  <= '0;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= chain[STEP_BITS];
        dvd_q <= dvd_q << STEP_BITS;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(STEPS-1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign rem  = rem_q;
endmodule

// File: rtl/tlb_rand_idx.sv
module tlb_rand_idx
  import tlb_rand_pkg::*;
#(
  parameter int ENTRIES   = 16,
  parameter int STEP_BITS = 4,
  localparam int IW = $clog2(ENTRIES),
  localparam int WW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [WW-1:0] wired,
  output logic          out_valid,
  output logic [IW-1:0] out_idx
);
  localparam int DVW = IW + 1;
  localparam logic [IW-1:0] TOP_IDX = IW'(ENTRIES-1);

  draw_st_e        state_q;
  logic [WW-1:0]   wired_q;
  logic [IW-1:0]   prev_q;
  logic            out_valid_q;
  logic [IW-1:0]   out_idx_q;

  logic              accept, sat_in, repeat_hit, draw_go;
  logic [LFSR_W-1:0] lfsr_state, lfsr_nxt;
  logic              mod_done;
  logic [DVW-1:0]    mod_rem, divisor, wired_src, cand_full;
  logic [IW-1:0]     cand;

  assign req_ready  = (state_q == ST_IDLE) && !out_valid_q;
  assign accept     = req_valid && req_ready;
  assign sat_in     = wired >= WW'(ENTRIES-1);
  assign wired_src  = accept ? wired : wired_q;
  assign divisor    = DVW'(ENTRIES) - wired_src;
  assign cand_full  = mod_rem + wired_q;
  assign cand       = cand_full[IW-1:0];
  assign repeat_hit = (state_q == ST_DRAW) && mod_done && (cand == prev_q);
  assign draw_go    = (accept && !sat_in) || repeat_hit;

  tlb_lfsr u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (draw_go),
    .state_o (lfsr_state),
    .next_o  (lfsr_nxt)
  );

  tlb_mod_unit #(
    .DW        (LFSR_W),
    .DVW       (DVW),
    .STEP_BITS (STEP_BITS)
  ) u_mod (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (draw_go),
    .dividend (lfsr_nxt),
    .divisor  (divisor),
    .done     (mod_done),
    .rem      (mod_rem)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      wired_q     <= '0;
      prev_q      <= '0;
      out_valid_q <= 1'b0;
      out_idx_q   <= '0;
    end else begin
      out_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          wired_q <= wired;
          if (sat_in) begin
            out_valid_q <= 1'b1;
            out_idx_q   <= TOP_IDX;
            prev_q      <= TOP_IDX;
          end else begin
            state_q <= ST_DRAW;
          end
        end
        ST_DRAW: if (mod_done && !repeat_hit) begin
          out_valid_q <= 1'b1;
          out_idx_q   <= cand;
          prev_q      <= cand;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign out_valid = out_valid_q;
  assign out_idx   = out_idx_q;
endmodule

// File: rtl/tlb_rand_idx_chk.sv
module tlb_rand_idx_chk #(
  parameter int ENTRIES = 16,
  localparam int IW = $clog2(ENTRIES),
  localparam int WW = IW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [WW-1:0] wired,
  input logic          out_valid,
  input logic [IW-1:0] out_idx
);
  logic [WW-1:0] wcap_q;
  logic [IW-1:0] last_q;
  logic          pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcap_q <= '0;
      last_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (req_valid && req_ready) begin
        wcap_q <= wired;
        pend_q <= 1'b1;
      end else if (out_valid) begin
        pend_q <= 1'b0;
      end
      if (out_valid) last_q <= out_idx;
    end
  end

  logic sat_cap;
  assign sat_cap = wcap_q >= WW'(ENTRIES-1);

  // R6
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R7
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R7
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> pend_q);
  // R3
  in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !sat_cap) |-> ({1'b0, out_idx} >= wcap_q));
  // R4
  no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !sat_cap) |-> (out_idx != last_q));
  // R5
  top_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sat_cap) |-> (out_idx == IW'(ENTRIES-1)));
endmodule

bind tlb_rand_idx tlb_rand_idx_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .wired     (wired),
  .out_valid (out_valid),
  .out_idx   (out_idx)
);

// File: tb/sim_tlb_rand_idx.sv
module sim_tlb_rand_idx;
  localparam int E  = 16;
  localparam int IW = $clog2(E);
  localparam int WW = IW + 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [WW-1:0] wired = '0;
  logic          out_valid;
  logic [IW-1:0] out_idx;

  tlb_rand_idx #(.ENTRIES(E)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .wired(wired), .out_valid(out_valid), .out_idx(out_idx)
  );

  int total = 0;
  int bad   = 0;
  logic [IW-1:0] expq[$];
  string         tagq[$];
  logic [31:0]   m_lfsr = 32'h1;
  logic [IW-1:0] m_prev = '0;
  logic          ov_d = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R2 R3 R4 R5: reference model
  function automatic logic [IW-1:0] model(input int w);
    logic [31:0] c;
    if (w >= E-1) begin
      m_prev = IW'(E-1);
      return m_prev;
    end
    do begin
      m_lfsr = (m_lfsr >> 1) ^ (m_lfsr[0] ? 32'hD000_0001 : 32'h0);
      c = (m_lfsr % 32'(E - w)) + 32'(w);
    end while (c[IW-1:0] == m_prev);
    m_prev = c[IW-1:0];
    return m_prev;
  endfunction

  task automatic send(input int w, input int w_after, input string tag);
    do @(negedge clk); while (!req_ready);
    expq.push_back(model(w));
    tagq.push_back(tag);
    wired     = WW'(w);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wired     = WW'(w_after);
    chk(req_ready == 1'b0, "R6 ready low after accept", int'(req_ready), 0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R7 result without request", int'(out_idx), -1);
        end else begin
          automatic logic [IW-1:0] e = expq.pop_front();
          automatic string t = tagq.pop_front();
          chk(out_idx == e, t, int'(out_idx), int'(e));
        end
        if (ov_d) chk(1'b0, "R7 pulse longer than one cycle", 1, 0);
      end
      ov_d <= out_valid;
    end
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(out_valid == 1'b0, "R1 no output after reset", int'(out_valid), 0);

    // R1 R2 R3: full window from seed
    for (int i = 0; i < 12; i++) send(0, 0, "R1 R2 R3 full window");
    // R3 R4: two-slot window forces redraws and strict alternation
    for (int i = 0; i < 16; i++) send(E-2, E-2, "R4 two-slot window");
    // R5: saturated bounds, LFSR untouched, last index updated
    send(E-1, 0, "R5 bound at top");
    send(E-2, E-2, "R4 R5 after top slot");
    send(E+3, 0, "R5 bound above top");
    send(E+3, 0, "R5 repeated top slot allowed");
    send(5, 5, "R3 mid window");
    // R8: bound changed while in flight
    for (int i = 0; i < 6; i++) send(9, 0, "R8 bound change ignored");
    for (int i = 0; i < 4; i++) send(3, E-1, "R8 bound change ignored");
    // R9: idle gaps do not advance LFSR
    for (int i = 0; i < 5; i++) begin
      repeat (20 + 7*i) @(negedge clk);
      send(2, 2, "R9 idle gap");
    end
    // mixed bounds back to back
    for (int i = 0; i < 16; i++) send((i * 5) % (E+2), 0, "R3 R4 R5 mixed bounds");

    while (expq.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule